// File: doc/BRIEF.md
# Transmitter Analog Power-Up Sequencer

This block brings the analog section of a display transmitter out of power-down. It drives seven active-high power-down controls: port, PLL, bandgap, VCO, PLL capacitor, IO deep-power-down and pad calibration. It walks them through a fixed five-step pattern and holds a timed settling interval between the steps.

Early in the sequence the block asks an external power controller to release deep-power-down. It then polls that controller's status at a fixed interval. When the status does not clear within the allowed window, the sequence stops with an error flag.

All delays come from one down-counter. The counter is loaded from microsecond parameters scaled by a cycles-per-microsecond parameter. Once the sequence has completed, a further start request has no effect and `done` simply stays high.

Top module: `tx_pwrup_seq`

## Requirements
- R1: After reset all seven controls are 1 (powered down) and busy, done, error and dpd_req are 0. The bench packs the controls as {port, pll, bandgap, vco, pllcap, iodpd, padcal}, bit 6 down to bit 0, so the reset pattern is 7'b1111111.
- R2: A start seen while idle clears iodpd in the following cycle (pattern 7'b1111101), raises busy, and raises dpd_req for exactly one cycle.
- R3: The status input is sampled every POLL_US*CYC_PER_US cycles after the request. The first sample comes that many cycles after the request cycle, and the sequence advances only on a sample that sees status low.
- R4: From the sample that sees status low, the controls hold for SETTLE_IO_US microseconds (15). The bandgap is then released, giving pattern 7'b1101101.
- R5: SETTLE_BG_US microseconds (25) after the bandgap release, PLL, VCO and PLL capacitor are released in the same cycle, giving pattern 7'b1000001.
- R6: SETTLE_PLL_US microseconds (225) later the port is released (pattern 7'b0000001), done rises and busy falls.
- R7: Pad calibration stays at 1 in every state.
- R8: A start while done is high issues no request and leaves the controls and done unchanged.
- R9: A start while busy has no effect on the sequence or its timing and issues no request.
- R10: If the TIMEOUT_US/POLL_US-th sample (the 500th) still sees status high, error rises and busy falls. The controls remain at 7'b1111101. Error is sticky: later starts and status changes have no effect.
- R11: Reset returns the controls to 7'b1111111 from any state and clears done and error.
- R12: Controls release in a fixed order. The bandgap never releases before iodpd, PLL/VCO/capacitor never before the bandgap, and the port never before PLL/VCO/capacitor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run the power-up sequence |
| dpd_status | input | 1 | Power controller status, 1 while the IO is still in deep-power-down |
| dpd_req | output | 1 | One-cycle deep-power-down release request to the power controller |
| pd_port | output | 1 | Port power-down |
| pd_pll | output | 1 | PLL power-down |
| pd_bandgap | output | 1 | Bandgap power-down |
| pd_vco | output | 1 | VCO power-down |
| pd_pllcap | output | 1 | PLL capacitor power-down |
| pd_iodpd | output | 1 | IO deep-power-down |
| pd_padcal | output | 1 | Pad calibration power-down |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed |
| error | output | 1 | Deep-power-down release timed out |

## Verification
The hardest condition to reach is the timeout. It needs the status to stay high through every one of the 500 polls, and the failure must land exactly at the last sample rather than one interval early or late. The bench sets cycles-per-microsecond to 2 so that the full 10 ms window fits in 20,000 cycles. It holds the status high throughout, checks busy one cycle before the final sample and error on that sample, and then toggles the status and start to show that the stop is sticky. A separate run clears the status only after two failed samples, which checks that the sequence lines up with the sample grid rather than with the status edge.

// File: rtl/tx_pwrup_pkg.sv
package tx_pwrup_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_POLL,
        ST_HOLD_IO,
        ST_HOLD_BG,
        ST_HOLD_PLL,
        ST_ON,
        ST_FAIL
    } seq_state_e;

    typedef struct packed {
        logic port;
        logic pll;
        logic bandgap;
        logic vco;
        logic pllcap;
        logic iodpd;
        logic padcal;
    } pd_ctrl_t;

    // Power-down pattern that each state presents on the macro controls.
    function automatic pd_ctrl_t ctrl_for(seq_state_e s);
        pd_ctrl_t c;
        c = '1;
        case (s)
            ST_POLL, ST_HOLD_IO, ST_FAIL: begin
                c.iodpd = 1'b0;
            end
            ST_HOLD_BG: begin
                c.iodpd   = 1'b0;
                c.bandgap = 1'b0;
            end
            ST_HOLD_PLL: begin
                c.iodpd   = 1'b0;
                c.bandgap = 1'b0;
                c.pll     = 1'b0;
                c.vco     = 1'b0;
                c.pllcap  = 1'b0;
            end
            ST_ON: begin
                c.iodpd   = 1'b0;
                c.bandgap = 1'b0;
                c.pll     = 1'b0;
                c.vco     = 1'b0;
                c.pllcap  = 1'b0;
                c.port    = 1'b0;
            end
            default: c = '1;
        endcase
        return c;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tx_pwrup_timer.sv
module tx_pwrup_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R3: a running interval never stalls above zero
    a_r3_timer_moves: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt < $past(cnt)));
endmodule

// File: rtl/tx_pwrup_dpd_watch.sv
module tx_pwrup_dpd_watch #(
    parameter int MAX_POLLS = 500,
    parameter int W         = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic miss,
    output logic last_try
);
    logic [W-1:0] tries;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tries <= '0;
        end else if (miss) begin
            tries <= tries + 1'b1;
        end
    end

    assign last_try = (tries == W'(MAX_POLLS - 1));

    // R10: a miss is never recorded past the final allowed sample
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
        miss |-> (tries < W'(MAX_POLLS - 1)));
endmodule

// File: rtl/tx_pwrup_fsm.sv
module tx_pwrup_fsm
    import tx_pwrup_pkg::*;
#(
    parameter int TW       = 16,
    parameter int POLL_CYC = 20,
    parameter int IO_CYC   = 15,
    parameter int BG_CYC   = 25,
    parameter int PLL_CYC  = 225
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       dpd_status,
    input  logic       expired,
    input  logic       last_try,
    output seq_state_e state,
    output logic       load,
    output logic [TW-1:0] load_val,
    output logic       watch_clr,
    output logic       miss,
    output logic       req
);
    seq_state_e nxt;

    always_comb begin
        nxt       = state;
        load      = 1'b0;
        load_val  = '0;
        watch_clr = 1'b0;
        miss      = 1'b0;
        case (state)
            ST_OFF: begin
                if (start) begin
                    nxt       = ST_POLL;
                    load      = 1'b1;
                    load_val  = TW'(POLL_CYC - 1);
                    watch_clr = 1'b1;
                end
            end
            ST_POLL: begin
                if (expired) begin
                    if (!dpd_status) begin
                        nxt      = ST_HOLD_IO;
                        load     = 1'b1;
                        load_val = TW'(IO_CYC - 1);
                    end else if (last_try) begin
                        nxt = ST_FAIL;
                    end else begin
                        load     = 1'b1;
                        load_val = TW'(POLL_CYC - 1);
                        miss     = 1'b1;
                    end
                end
            end
            ST_HOLD_IO: begin
                if (expired) begin
                    nxt      = ST_HOLD_BG;
                    load     = 1'b1;
                    load_val = TW'(BG_CYC - 1);
                end
            end
            ST_HOLD_BG: begin
                if (expired) begin
                    nxt      = ST_HOLD_PLL;
                    load     = 1'b1;
                    load_val = TW'(PLL_CYC - 1);
                end
            end
            ST_HOLD_PLL: begin
                if (expired) nxt = ST_ON;
            end
            default: nxt = state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OFF;
            req   <= 1'b0;
        end else begin
            state <= nxt;
            req   <= (state == ST_OFF) && start;
        end
    end

    // R10: the failure state is terminal until reset
    a_r10_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAIL) |=> (state == ST_FAIL));
    // R8: completion is terminal until reset
    a_r8_on_sticky: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ON) |=> (state == ST_ON));
endmodule

// File: rtl/tx_pwrup_seq.sv
module tx_pwrup_seq
    import tx_pwrup_pkg::*;
#(
    parameter int CYC_PER_US    = 100,
    parameter int SETTLE_IO_US  = 15,
    parameter int SETTLE_BG_US  = 25,
    parameter int SETTLE_PLL_US = 225,
    parameter int POLL_US       = 20,
    parameter int TIMEOUT_US    = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic dpd_status,
    output logic dpd_req,
    output logic pd_port,
    output logic pd_pll,
    output logic pd_bandgap,
    output logic pd_vco,
    output logic pd_pllcap,
    output logic pd_iodpd,
    output logic pd_padcal,
    output logic busy,
    output logic done,
    output logic error
);
    localparam int POLL_CYC  = POLL_US * CYC_PER_US;
    localparam int IO_CYC    = SETTLE_IO_US * CYC_PER_US;
    localparam int BG_CYC    = SETTLE_BG_US * CYC_PER_US;
    localparam int PLL_CYC   = SETTLE_PLL_US * CYC_PER_US;
    localparam int MAX_CYC   = int'(max3(POLL_CYC, IO_CYC, max3(BG_CYC, PLL_CYC, 1)));
    localparam int TW        = $clog2(MAX_CYC + 1);
    localparam int MAX_POLLS = TIMEOUT_US / POLL_US;
    localparam int PW        = $clog2(MAX_POLLS + 1);

    seq_state_e    state;
    logic          load;
    logic [TW-1:0] load_val;
    logic          expired;
    logic          watch_clr;
    logic          miss;
    logic          last_try;
    pd_ctrl_t      ctrl;

    tx_pwrup_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    tx_pwrup_dpd_watch #(.MAX_POLLS(MAX_POLLS), .W(PW)) u_watch (
        .clk      (clk),
        .rst      (rst),
        .clr      (watch_clr),
        .miss     (miss),
        .last_try (last_try)
    );

    tx_pwrup_fsm #(
        .TW       (TW),
        .POLL_CYC (POLL_CYC),
        .IO_CYC   (IO_CYC),
        .BG_CYC   (BG_CYC),
        .PLL_CYC  (PLL_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .dpd_status (dpd_status),
        .expired    (expired),
        .last_try   (last_try),
        .state      (state),
        .load       (load),
        .load_val   (load_val),
        .watch_clr  (watch_clr),
        .miss       (miss),
        .req        (dpd_req)
    );

    assign ctrl       = ctrl_for(state);
    assign pd_port    = ctrl.port;
    assign pd_pll     = ctrl.pll;
    assign pd_bandgap = ctrl.bandgap;
    assign pd_vco     = ctrl.vco;
    assign pd_pllcap  = ctrl.pllcap;
    assign pd_iodpd   = ctrl.iodpd;
    assign pd_padcal  = ctrl.padcal;
    assign busy  = (state == ST_POLL) || (state == ST_HOLD_IO) ||
                   (state == ST_HOLD_BG) || (state == ST_HOLD_PLL);
    assign done  = (state == ST_ON);
    assign error = (state == ST_FAIL);

    // R12: release ordering
    a_r12_bg_after_io: assert property (@(posedge clk) disable iff (rst)
        !pd_bandgap |-> !pd_iodpd);
    a_r12_pll_after_bg: assert property (@(posedge clk) disable iff (rst)
        (!pd_pll || !pd_vco || !pd_pllcap) |-> (!pd_bandgap && pd_pll == pd_vco && pd_vco == pd_pllcap));
    a_r12_port_last: assert property (@(posedge clk) disable iff (rst)
        !pd_port |-> (!pd_pll && !pd_vco && !pd_pllcap));
    // R2: request lasts one cycle and only while the sequence runs
    a_r2_req_pulse: assert property (@(posedge clk) disable iff (rst)
        dpd_req |-> (busy && pd_padcal) ##1 !dpd_req);
    // R8: start while done issues no request
    a_r8_no_req_when_done: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> (!dpd_req && done));
    // R10: error freezes the controls
    a_r10_err_frozen: assert property (@(posedge clk) disable iff (rst)
        error |=> (error && $stable(ctrl) && !busy));
    // R6: busy and done never overlap
    a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
    // R11: reset lands on the fully powered-down pattern
    a_r11_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (ctrl == '1 && !done && !error));
endmodule

// File: tb/tx_pwrup_seq_bench.sv
module tx_pwrup_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 2;
    localparam logic [6:0] P1 = 7'b1111111;
    localparam logic [6:0] P2 = 7'b1111101;
    localparam logic [6:0] P3 = 7'b1101101;
    localparam logic [6:0] P4 = 7'b1000001;
    localparam logic [6:0] P5 = 7'b0000001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic dpd_status = 1'b1;
    logic dpd_req, pd_port, pd_pll, pd_bandgap, pd_vco, pd_pllcap, pd_iodpd, pd_padcal;
    logic busy, done, error;
    int   n_checks = 0;
    int   n_fail   = 0;
    int   cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_pwrup_seq #(.CYC_PER_US(CPU)) u_tx_pwrup_seq (
        .clk(clk), .rst(rst), .start(start), .dpd_status(dpd_status),
        .dpd_req(dpd_req), .pd_port(pd_port), .pd_pll(pd_pll),
        .pd_bandgap(pd_bandgap), .pd_vco(pd_vco), .pd_pllcap(pd_pllcap),
        .pd_iodpd(pd_iodpd), .pd_padcal(pd_padcal),
        .busy(busy), .done(done), .error(error)
    );

    function automatic logic [6:0] ctrls();
        return {pd_port, pd_pll, pd_bandgap, pd_vco, pd_pllcap, pd_iodpd, pd_padcal};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_ctrl(input string tag, input logic [6:0] exp);
        chk(ctrls() == exp, tag, 32'(ctrls()), 32'(exp));
    endtask

    task automatic chk_flags(input string tag, input logic b, input logic d, input logic e);
        chk({busy, done, error} == {b, d, e}, tag, 32'({busy, done, error}), 32'({b, d, e}));
    endtask

    task automatic go(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        go(1);
        start = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        go(2);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        chk_ctrl("R1 reset controls", P1);
        chk_flags("R1 reset flags", 1'b0, 1'b0, 1'b0);
        chk(dpd_req == 1'b0, "R1 reset req", 32'(dpd_req), 0);
    endtask

    task automatic t_full_sequence();
        dpd_status = 1'b1;
        pulse_start();                 // after E0
        chk_ctrl("R2 step2 pattern", P2);
        chk(dpd_req == 1'b1, "R2 request raised", 32'(dpd_req), 1);
        chk_flags("R2 busy", 1'b1, 1'b0, 1'b0);
        go(1);                         // E1
        chk(dpd_req == 1'b0, "R2 request one cycle", 32'(dpd_req), 0);
        go(99);                        // E100, two misses at E40 and E80
        chk_ctrl("R3 held while status set", P2);
        dpd_status = 1'b0;
        go(19);                        // E119
        chk_ctrl("R3 waits for sample grid", P2);
        go(30);                        // E149
        chk_ctrl("R4 io settle hold", P2);
        go(1);                         // E150
        chk_ctrl("R4 bandgap released", P3);
        go(10);                        // E160
        pulse_start();                 // E161
        chk(dpd_req == 1'b0, "R9 start while busy no request", 32'(dpd_req), 0);
        go(38);                        // E199
        chk_ctrl("R5 bandgap settle hold", P3);
        go(1);                         // E200
        chk_ctrl("R5 pll vco cap released", P4);
        go(449);                       // E649
        chk_ctrl("R9 timing unchanged by start", P4);
        chk_flags("R6 still busy", 1'b1, 1'b0, 1'b0);
        go(1);                         // E650
        chk_ctrl("R6 port released", P5);
        chk_flags("R6 done", 1'b0, 1'b1, 1'b0);
        chk(pd_padcal == 1'b1, "R7 padcal held", 32'(pd_padcal), 1);
    endtask

    task automatic t_start_when_done();
        pulse_start();
        chk(dpd_req == 1'b0, "R8 no request when done", 32'(dpd_req), 0);
        go(3);
        chk_ctrl("R8 controls unchanged", P5);
        chk_flags("R8 done stays", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_reset_from_done();
        do_reset();
        chk_ctrl("R11 reset from done controls", P1);
        chk_flags("R11 reset from done flags", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_first_sample_clear();
        dpd_status = 1'b0;
        pulse_start();                 // E0
        go(39);                        // E39
        chk_ctrl("R3 before first sample", P2);
        go(31);                        // E70
        chk_ctrl("R3 advanced on first sample", P3);
        do_reset();
    endtask

    task automatic t_timeout();
        dpd_status = 1'b1;
        pulse_start();                 // E0
        go(19999);                     // E19999
        chk_flags("R10 busy before last sample", 1'b1, 1'b0, 1'b0);
        go(1);                         // E20000
        chk_flags("R10 error on last sample", 1'b0, 1'b0, 1'b1);
        chk_ctrl("R10 step2 pattern kept", P2);
        chk(pd_padcal == 1'b1, "R7 padcal held on error", 32'(pd_padcal), 1);
        pulse_start();
        chk(dpd_req == 1'b0, "R10 start ignored after error", 32'(dpd_req), 0);
        dpd_status = 1'b0;
        go(60);
        chk_ctrl("R10 no advance after error", P2);
        chk_flags("R10 error sticky", 1'b0, 1'b0, 1'b1);
        do_reset();
        chk_ctrl("R11 reset from error controls", P1);
        chk_flags("R11 reset clears error", 1'b0, 1'b0, 1'b0);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        go(3);
        rst = 1'b0;
        t_reset_state();
        t_full_sequence();
        t_start_when_done();
        t_reset_from_done();
        t_first_sample_clear();
        t_timeout();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule